// File: doc/BRIEF.md
# Interrupt Status Unit for a Serial Master

This block collects the interrupt conditions of a serial master controller into a status register, masks them with an enable register and raises one level-high interrupt request. Condition inputs arrive as a vector whose bit positions match the status register. A level condition, such as a FIFO being full or holding data, keeps its status bit set for as long as it is present. An event condition, such as the all-done pulse, sets its bit, and the bit stays set after the pulse ends.

Software reaches the block through a simple word-addressed read/write port. It reads status, reads and writes the enable mask, and clears status bits by writing ones to a write-only clear register. A bit whose condition is still asserted is set again on the next edge. Software can therefore clear a bit and read it back to sample the live condition. Driver code that polls FIFO state relies on this.

Top module: `irq_status_unit`

## Requirements
- R1: After a synchronous reset, the status register, the enable register, the read data and the interrupt output are all zero.
- R2: A condition input high at a rising edge sets the status bit at the same position. The positions are: 0 transmit threshold, 1 transmit empty, 2 transmit half-full, 3 transmit full, 5 receive threshold, 6 receive holds a 32-bit word, 7 receive half-full, 8 receive full, 9 all-done, 11 receive holds a byte, 12 illegal access.
- R3: A write to the clear register (offset 8 from the base) clears each status bit whose write-data bit is 1. A 0 in the write data leaves the bit unchanged.
- R4: When a clear and a high condition meet on the same bit in the same cycle, the bit stays set. A level condition held high across a clear therefore reads back as set.
- R5: A status bit, once set, stays set after its condition drops until it is cleared. This is how the all-done event (bit 9) is held.
- R6: Bits 4 and 10 are reserved. They read as zero in status and in enable, and condition inputs and writes on those positions have no effect.
- R7: The status register (offset 0) is read-only, so writes to it are ignored. The enable register (offset 4) is read/write. The clear register (offset 8) reads as zero.
- R8: The interrupt output is registered. In each cycle it equals the OR, over all bits, of status AND enable as they stood in the previous cycle.
- R9: Read data is registered. The cycle after a read strobe, it holds the value the addressed register had before that edge. The value is held while no read is strobed, and an unmapped address reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cond_i | input | 13 | Condition inputs, one per status bit position |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Level-high interrupt request |

## Verification
Two operations can land on the same bit in the same cycle: a software clear and a hardware set. The bench provokes this in two ways. It holds a FIFO-full condition high while writing the clear register, and it pulses the all-done event in exactly the cycle the clear is written. Both bits must read back as set. A behavioural model, which applies the clear before the condition every cycle, judges both the read value and the interrupt level on every clock.

// File: rtl/isu_pkg.sv
package isu_pkg;
  localparam int ISU_NBITS = 13;
  localparam int B_TX_TRIG = 0;
  localparam int B_TX_EMPTY = 1;
  localparam int B_TX_HALF = 2;
  localparam int B_TX_FULL = 3;
  localparam int B_RX_TRIG = 5;
  localparam int B_RX_WORD = 6;
  localparam int B_RX_HALF = 7;
  localparam int B_RX_FULL = 8;
  localparam int B_ALL_DONE = 9;
  localparam int B_RX_BYTE = 11;
  localparam int B_BAD_ACC = 12;
  // reserved positions 4 and 10
  localparam logic [ISU_NBITS-1:0] ISU_RSVD = 13'h0410;
endpackage

// File: rtl/isu_status_bank.sv
module isu_status_bank #(
  parameter int NBITS = isu_pkg::ISU_NBITS,
  parameter logic [NBITS-1:0] RSVD = isu_pkg::ISU_RSVD
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NBITS-1:0] cond_i,
  input  logic [NBITS-1:0] clr_i,
  output logic [NBITS-1:0] stat_o
);
  for (genvar b = 0; b < NBITS; b++) begin : g_bit
    if (RSVD[b]) begin : g_rsvd
      assign stat_o[b] = 1'b0;
    end else begin : g_live
      logic bit_q;
      always_ff @(posedge clk) begin
        if (rst) bit_q <= 1'b0;
        else     bit_q <= (bit_q & ~clr_i[b]) | cond_i[b];
      end
      assign stat_o[b] = bit_q;

      // R4
      set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        cond_i[b] |=> bit_q);
      // R3
      clr_takes_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_i[b] && !cond_i[b]) |=> !bit_q);
      // R5
      sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_q && !clr_i[b]) |=> bit_q);
    end
  end
endmodule

// File: rtl/isu_enable_reg.sv
module isu_enable_reg #(
  parameter int NBITS = isu_pkg::ISU_NBITS,
  parameter logic [NBITS-1:0] RSVD = isu_pkg::ISU_RSVD
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we_i,
  input  logic [NBITS-1:0] d_i,
  output logic [NBITS-1:0] en_o
);
  logic [NBITS-1:0] en_q;
  always_ff @(posedge clk) begin
    if (rst)       en_q <= '0;
    else if (we_i) en_q <= d_i & ~RSVD;
  end
  assign en_o = en_q;

  // R6
  en_rsvd_chk: assert property (@(posedge clk) disable iff (rst)
    we_i |=> ((en_o & RSVD) == '0));
endmodule

// File: rtl/isu_reg_port.sv
module isu_reg_port #(
  parameter int NBITS = isu_pkg::ISU_NBITS,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int BASE = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NBITS-1:0]  stat_i,
  input  logic [NBITS-1:0]  en_i,
  output logic              en_we_o,
  output logic [NBITS-1:0]  wbits_o,
  output logic [NBITS-1:0]  clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(BASE + 4);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(BASE + 8);

  logic unused_hi;
  assign unused_hi = ^wdata_i[DATA_W-1:NBITS];

  assign wbits_o = wdata_i[NBITS-1:0];
  assign en_we_o = wr_en_i && (addr_i == A_EN);
  assign clr_o   = (wr_en_i && (addr_i == A_CLR)) ? wdata_i[NBITS-1:0] : '0;

  logic [NBITS-1:0]  rsel;
  logic [DATA_W-1:0] rdata_q;
  always_comb begin
    unique case (addr_i)
      A_STAT:  rsel = stat_i;
      A_EN:    rsel = en_i;
      default: rsel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata_q <= '0;
    else if (rd_en_i) rdata_q <= DATA_W'(rsel);
  end
  assign rdata_o = rdata_q;

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> $stable(rdata_q));
  // R7
  clr_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && addr_i == A_CLR) |=> (rdata_q == '0));
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit #(
  parameter int NBITS = isu_pkg::ISU_NBITS,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int BASE = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NBITS-1:0]  cond_i,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic [NBITS-1:0] stat, en, clr, wbits;
  logic en_we, irq_q;

  isu_reg_port #(.NBITS(NBITS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE(BASE)) u_port (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .stat_i(stat), .en_i(en), .en_we_o(en_we),
    .wbits_o(wbits), .clr_o(clr), .rdata_o(rdata)
  );

  isu_status_bank #(.NBITS(NBITS)) u_stat (
    .clk(clk), .rst(rst), .cond_i(cond_i), .clr_i(clr), .stat_o(stat)
  );

  isu_enable_reg #(.NBITS(NBITS)) u_en (
    .clk(clk), .rst(rst), .we_i(en_we), .d_i(wbits), .en_o(en)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(stat & en);
  end
  assign irq = irq_q;

  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ((stat & en) == '0) |=> !irq);
  // R8
  irq_raise_chk: assert property (@(posedge clk) disable iff (rst)
    ((stat & en) != '0) |=> irq);
endmodule

// File: tb/tb_irq_status_unit.sv
module tb_irq_status_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [12:0] cond_i = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq;
  int total = 0, bad = 0;
  bit done = 1'b0;

  localparam logic [12:0] RSV = 13'h0410;

  always #5 clk = ~clk;

  irq_status_unit dut (.clk(clk), .rst(rst), .cond_i(cond_i), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  // behavioural reference
  logic [12:0] m_stat = '0, m_en = '0;
  logic [31:0] m_rd = '0;
  logic m_irq = 1'b0;
  always @(posedge clk) begin
    logic [12:0] c;
    logic [31:0] r;
    if (rst) begin
      m_stat = '0; m_en = '0; m_rd = '0; m_irq = 1'b0;
    end else begin
      c = (wr_en && addr == 8'd8) ? wdata[12:0] : 13'h0;
      r = (addr == 8'd0) ? {19'h0, m_stat} : (addr == 8'd4) ? {19'h0, m_en} : 32'h0;
      m_irq = |(m_stat & m_en);
      if (rd_en) m_rd = r;
      m_stat = ((m_stat & ~c) | cond_i) & ~RSV;
      if (wr_en && addr == 8'd4) m_en = wdata[12:0] & ~RSV;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (!rst && !done) begin
    chk("R9 model rdata", rdata, m_rd);
    chk("R8 model irq", {31'h0, irq}, {31'h0, m_irq});
  end

  task automatic tick(); @(negedge clk); endtask
  task automatic wr(logic [7:0] a, logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d; tick(); wr_en = 1'b0;
  endtask
  task automatic rd(logic [7:0] a, output logic [31:0] v);
    rd_en = 1'b1; addr = a; tick(); rd_en = 1'b0; v = rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) tick();
    rst = 1'b0;
    // R1 reset state
    chk("R1 rdata", rdata, 0);
    chk("R1 irq", {31'h0, irq}, 0);
    rd(8'd0, v); chk("R1 status", v, 0);
    rd(8'd4, v); chk("R1 enable", v, 0);
    // R2/R5 all-done pulse holds
    cond_i[9] = 1'b1; tick(); cond_i = '0;
    repeat (4) tick();
    rd(8'd0, v); chk("R5 event held", v, 32'h200);
    // R3 zero write no effect, one clears
    wr(8'd8, 32'h0); rd(8'd0, v); chk("R3 zero clear", v, 32'h200);
    wr(8'd8, 32'h200); rd(8'd0, v); chk("R3 one clear", v, 0);
    // R4 level held across clear
    cond_i[3] = 1'b1; tick();
    wr(8'd8, 32'h8); rd(8'd0, v); chk("R4 level resets", v, 32'h8);
    cond_i = '0; wr(8'd8, 32'h8); rd(8'd0, v); chk("R3 level cleared", v, 0);
    // R4 event and clear in same cycle
    cond_i[9] = 1'b1; wr(8'd8, 32'h200); cond_i = '0;
    rd(8'd0, v); chk("R4 same cycle", v, 32'h200);
    // R2/R6 all conditions, reserved ignored
    cond_i = 13'h1FFF; tick(); cond_i = '0;
    rd(8'd0, v); chk("R2 R6 all bits", v, 32'h1BEF);
    // R7 status read-only
    wr(8'd0, 32'h0); rd(8'd0, v); chk("R7 status ro", v, 32'h1BEF);
    // R6/R7 enable rw with reserved
    wr(8'd4, 32'hFFFF_FFFF); rd(8'd4, v); chk("R6 enable rsvd", v, 32'h1BEF);
    rd(8'd8, v); chk("R7 clear reads 0", v, 0);
    // R8 interrupt timing
    wr(8'd4, 32'h1000); wr(8'd8, 32'h1FFF); tick();
    chk("R8 quiet", {31'h0, irq}, 0);
    cond_i[12] = 1'b1; tick(); cond_i = '0;
    chk("R8 not yet", {31'h0, irq}, 0);
    tick(); chk("R8 raised", {31'h0, irq}, 1);
    cond_i[8] = 1'b1; tick(); cond_i = '0;
    wr(8'd8, 32'h1000); chk("R8 still high", {31'h0, irq}, 1);
    tick(); chk("R8 dropped masked", {31'h0, irq}, 0);
    // R9 hold without strobe, unmapped reads zero
    rd(8'd0, v); chk("R9 read", v, 32'h100);
    addr = 8'd4; repeat (3) tick(); chk("R9 hold", rdata, 32'h100);
    rd(8'd40, v); chk("R9 unmapped", v, 0);
    // R1 reset mid-run
    rst = 1'b1; tick(); tick(); rst = 1'b0;
    chk("R1 rst irq", {31'h0, irq}, 0);
    rd(8'd0, v); chk("R1 rst status", v, 0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule